// File: doc/BRIEF.md
# Accumulator Add/Subtract Unit with Status Flags

This block holds an 8-bit accumulator and four status flags: negative, overflow, zero and carry. When the operation strobe is high for one cycle, it adds an 8-bit operand and the carry flag to the accumulator, or subtracts the operand. It writes the low byte of the result back to the accumulator and updates all four flags in the same clock edge. The unit works on binary values only.

Subtraction uses the same 9-bit adder as addition. The operand is inverted bit by bit, and the carry flag acts as an inverted borrow, so carry set means "no borrow". The adder does not know whether the values are signed or unsigned. The carry flag reports unsigned overflow and the overflow flag reports signed overflow. It is up to the user to read the flag that matches the intent.

Two load strobes let the surrounding logic set the accumulator directly and set or clear the carry flag directly. A load has priority over an operation issued in the same cycle.

Top module: `acc_alu`

## Requirements
- R1: While rst_ni is low, the accumulator and all four flags are zero, and they stay zero until the first strobe after reset is released.
- R2: On an add operation (op_valid_i=1, op_sub_i=0, no load strobe), the accumulator becomes (acc + operand + carry) mod 256.
- R3: On a subtract operation (op_valid_i=1, op_sub_i=1, no load strobe), the accumulator becomes (acc + (operand XOR 8'hFF) + carry) mod 256. This equals acc - operand - (1 - carry).
- R4: On any operation, carry_o takes bit 8 of the 9-bit sum. After an add, 1 means unsigned overflow. After a subtract, 0 means a borrow occurred.
- R5: On any operation, ovf_o is set in two cases: both adder inputs (the accumulator and the possibly inverted operand) have bit 7 clear and the result has bit 7 set, or both have bit 7 set and the result has bit 7 clear. In every other case ovf_o is cleared.
- R6: On any operation, neg_o is set to bit 7 of the new accumulator.
- R7: On any operation, zero_o is set when the new accumulator is 8'h00 and cleared otherwise.
- R8: When op_valid_i and both load strobes are low, the accumulator and all flags hold their values.
- R9: acc_load_i=1 loads acc_load_val_i into the accumulator, and carry_load_i=1 loads carry_load_val_i into carry_o. If either load strobe is high, an operation requested in the same cycle is suppressed, and state not named by a load holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation strobe |
| op_sub_i | input | 1 | 1 = subtract with borrow, 0 = add with carry |
| operand_i | input | 8 | Second operand |
| acc_load_i | input | 1 | Accumulator load strobe |
| acc_load_val_i | input | 8 | Accumulator load value |
| carry_load_i | input | 1 | Carry flag load strobe |
| carry_load_val_i | input | 1 | Carry flag load value |
| acc_o | output | 8 | Accumulator |
| neg_o | output | 1 | Negative flag |
| ovf_o | output | 1 | Signed overflow flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag (inverted borrow after a subtract) |

## Verification
The bench aims at the sign-boundary cases, which are the likeliest places for an error:
- 0x7F+0x01 and 0x80+0x80 must set overflow. A design that takes overflow from the raw operand instead of the inverted one gets 0x80-0x01 and 0x7F-0xFF wrong.
- Subtraction with the carry clear must take one extra unit away. A design that ignores the carry-in is off by one there.
- 0xFF+0x01 must give a zero result with carry set. A design that computes the zero flag from the 9-bit sum misses this case.
- A load issued together with an operation must win. A design that gives the operation priority leaves the sum in place of the loaded value.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic zero;
    logic carry;
  } flags_t;
endpackage

// File: rtl/acc_alu_opsel.sv
// Conditions the second adder input: per-bit invert on subtract.
module acc_alu_opsel #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] operand_i,
  input  logic         sub_i,
  output logic [W-1:0] operand_o
);
  for (genvar i = 0; i < W; i++) begin : g_inv
    assign operand_o[i] = operand_i[i] ^ sub_i;
  end
endmodule

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W:0]   sum_o
);
  assign sum_o = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W:0]   sum_i,
  output flags_t       flags_o
);
  localparam int unsigned MSB = W - 1;

  logic res_msb;
  assign res_msb = sum_i[MSB];

  always_comb begin
    flags_o.neg   = res_msb;
    // signed overflow: inputs agree in sign, result differs
    flags_o.ovf   = (~a_i[MSB] & ~b_i[MSB] & res_msb) | (a_i[MSB] & b_i[MSB] & ~res_msb);
    flags_o.zero  = (sum_i[W-1:0] == '0);
    flags_o.carry = sum_i[W];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         op_valid_i,
  input  logic         op_sub_i,
  input  logic [W-1:0] operand_i,
  input  logic         acc_load_i,
  input  logic [W-1:0] acc_load_val_i,
  input  logic         carry_load_i,
  input  logic         carry_load_val_i,
  output logic [W-1:0] acc_o,
  output logic         neg_o,
  output logic         ovf_o,
  output logic         zero_o,
  output logic         carry_o
);
  logic [W-1:0] acc_q;
  flags_t       flags_q, flags_nxt;
  logic [W-1:0] b_in;
  logic [W:0]   sum;
  logic         any_load, do_op;

  acc_alu_opsel #(.W(W)) u_opsel (
    .operand_i (operand_i),
    .sub_i     (op_sub_i),
    .operand_o (b_in)
  );

  acc_alu_adder #(.W(W)) u_adder (
    .a_i   (acc_q),
    .b_i   (b_in),
    .cin_i (flags_q.carry),
    .sum_o (sum)
  );

  acc_alu_flags #(.W(W)) u_flags (
    .a_i     (acc_q),
    .b_i     (b_in),
    .sum_i   (sum),
    .flags_o (flags_nxt)
  );

  assign any_load = acc_load_i | carry_load_i;
  assign do_op    = op_valid_i & ~any_load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      flags_q <= '0;
    end else if (any_load) begin
      if (acc_load_i)   acc_q         <= acc_load_val_i;
      if (carry_load_i) flags_q.carry <= carry_load_val_i;
    end else if (do_op) begin
      acc_q   <= sum[W-1:0];
      flags_q <= flags_nxt;
    end
  end

  assign acc_o   = acc_q;
  assign neg_o   = flags_q.neg;
  assign ovf_o   = flags_q.ovf;
  assign zero_o  = flags_q.zero;
  assign carry_o = flags_q.carry;
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         op_valid_i,
  input logic         op_sub_i,
  input logic [W-1:0] operand_i,
  input logic         acc_load_i,
  input logic [W-1:0] acc_load_val_i,
  input logic         carry_load_i,
  input logic         carry_load_val_i,
  input logic [W-1:0] acc_o,
  input logic         neg_o,
  input logic         ovf_o,
  input logic         zero_o,
  input logic         carry_o
);
  logic op_only;
  assign op_only = op_valid_i & ~acc_load_i & ~carry_load_i;

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |=> (acc_o == '0 && !neg_o && !ovf_o && !zero_o && !carry_o) || rst_ni); // R1

  AST_SUM_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_only |=> {carry_o, acc_o} ==
      ({1'b0, $past(acc_o)} + {1'b0, ($past(operand_i) ^ {W{$past(op_sub_i)}})}
       + {{W{1'b0}}, $past(carry_o)})); // R4

  AST_SIGNED_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_only |=> ovf_o == (($past(acc_o[W-1]) == ($past(operand_i[W-1]) ^ $past(op_sub_i)))
                          && (acc_o[W-1] != $past(acc_o[W-1])))); // R5

  AST_NEG_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_only |=> neg_o == acc_o[W-1]); // R6

  AST_ZERO_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_only |=> zero_o == (acc_o == '0)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i && !acc_load_i && !carry_load_i) |=>
      ($stable(acc_o) && $stable(neg_o) && $stable(ovf_o) && $stable(zero_o) && $stable(carry_o))); // R8

  AST_ACC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_load_i |=> acc_o == $past(acc_load_val_i)); // R9

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_load_i && !acc_load_i) |=>
      ($stable(acc_o) && $stable(neg_o) && $stable(ovf_o) && $stable(zero_o)
       && carry_o == $past(carry_load_val_i))); // R9
endmodule

bind acc_alu acc_alu_checker #(.W(W)) u_acc_alu_checker (.*);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  localparam int unsigned W = 8;
  localparam int unsigned N_RAND = 20000;
  localparam int unsigned WDOG_CYC = 150000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         op_valid_i = 1'b0, op_sub_i = 1'b0;
  logic [W-1:0] operand_i = '0;
  logic         acc_load_i = 1'b0, carry_load_i = 1'b0, carry_load_val_i = 1'b0;
  logic [W-1:0] acc_load_val_i = '0;
  logic [W-1:0] acc_o;
  logic         neg_o, ovf_o, zero_o, carry_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  acc_alu u_acc_alu (.*);

  // reference: integer arithmetic for value, signed ranges for overflow
  function automatic logic [11:0] ref_op(input int a, input int b, input int cin, input bit sub);
    int s, sa, sb, ss, res;
    logic v;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    if (sub) begin
      s  = a - b - (1 - cin) + 256;
      ss = sa - sb - (1 - cin);
    end else begin
      s  = a + b + cin;
      ss = sa + sb + cin;
    end
    res = s % 256;
    v = (ss > 127) || (ss < -128);
    // {acc, neg, ovf, zero, carry}
    return {res[7:0], (res > 127), v, (res == 0), (s > 255)};
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual acc=%h nvzc=%b expected acc=%h nvzc=%b",
               req, act[11:4], act[3:0], exp[11:4], exp[3:0]);
    end
  endtask

  function automatic logic [11:0] state();
    return {acc_o, neg_o, ovf_o, zero_o, carry_o};
  endfunction

  task automatic run_op(input int a, input int b, input int cin, input bit sub, input string req);
    @(negedge clk_i);
    acc_load_i = 1'b1; acc_load_val_i = a[7:0];
    carry_load_i = 1'b1; carry_load_val_i = cin[0];
    @(negedge clk_i);
    acc_load_i = 1'b0; carry_load_i = 1'b0;
    op_valid_i = 1'b1; op_sub_i = sub; operand_i = b[7:0];
    @(negedge clk_i);
    op_valid_i = 1'b0;
    check(req, state(), ref_op(a, b, cin, sub));
  endtask

  initial begin
    logic [11:0] snap;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    check("R1 reset", state(), 12'h000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", state(), 12'h000);

    run_op(8'h7F, 8'h01, 0, 1'b0, "R5 add pos overflow");
    run_op(8'h80, 8'h80, 0, 1'b0, "R4 R5 R7 add neg overflow");
    run_op(8'hFF, 8'h01, 0, 1'b0, "R4 R7 wrap to zero");
    run_op(8'h10, 8'h20, 1, 1'b0, "R2 add carry-in");
    run_op(8'h80, 8'h01, 1, 1'b1, "R3 R5 sub neg overflow");
    run_op(8'h7F, 8'hFF, 1, 1'b1, "R3 R5 sub pos overflow");
    run_op(8'h05, 8'h05, 0, 1'b1, "R3 R4 borrow-in");
    run_op(8'h05, 8'h05, 1, 1'b1, "R3 R7 sub to zero");
    run_op(8'h00, 8'h01, 1, 1'b1, "R4 R6 sub borrow out");

    // R8: idle hold
    snap = state();
    repeat (5) @(negedge clk_i);
    check("R8 idle hold", state(), snap);

    // R9: accumulator load beats operation
    @(negedge clk_i);
    op_valid_i = 1'b1; op_sub_i = 1'b0; operand_i = 8'h01;
    acc_load_i = 1'b1; acc_load_val_i = 8'h3C;
    @(negedge clk_i);
    op_valid_i = 1'b0; acc_load_i = 1'b0;
    check("R9 acc load priority", state(), {8'h3C, snap[3:0]});

    // R9: carry load alone beats operation, acc and other flags hold
    snap = state();
    op_valid_i = 1'b1; operand_i = 8'h44;
    carry_load_i = 1'b1; carry_load_val_i = ~snap[0];
    @(negedge clk_i);
    op_valid_i = 1'b0; carry_load_i = 1'b0;
    check("R9 carry load priority", state(), {snap[11:1], ~snap[0]});

    for (int i = 0; i < N_RAND; i++) begin
      int a, b, c;
      bit s;
      a = $urandom_range(255, 0);
      b = $urandom_range(255, 0);
      c = $urandom_range(1, 0);
      s = $urandom_range(1, 0);
      run_op(a, b, c, s, s ? "R3 R5 R6 random sub" : "R2 R5 R6 random add");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule